// File: doc/BRIEF.md
# Memory Attribute and Alignment Checker

This block sits beside a protection unit. It receives one memory access per clock, together with the attributes of the protection region that the access hit. It decides what attributes the access really carries and whether the access must fault.

Two programmable tightly coupled memory windows take part in that decision. An access that lands in either window is always handled as plain Normal, non-cacheable memory. The one exception is that an ordered region type (Device or Strongly Ordered) still makes the address non-executable. Outside the windows, ordered regions need each element naturally aligned. Normal memory checks alignment only when strict alignment is switched on, or for multiple-transfer accesses.

Every result is registered and appears one clock after the request. A downstream pipeline stage reads the effective attributes and the two fault flags.

Top module: `memAttrCheck`

## Requirements
- R1: While reset is asserted, and until the first request is captured, the outputs are effType=2'b10, effCache=0, effShare=0, alignFault=0, permFault=0 and tcmHit=0.
- R2: Every output reflects the inputs sampled at the previous rising clock edge, one result per cycle with no gaps.
- R3: With regionHit=0 the access is Normal (effType=2'b10), non-cacheable, non-shareable and executable. effCache is 1 only when a region hits, the address is outside both windows, the region type is Normal and regionCache is 1.
- R4: tcmHit is 1 when an enabled window satisfies ((accAddr ^ base) & ~mask) == 0. Mask bits set to 1 mark offset bits inside the window. On a hit, effType=2'b10 and effCache=0, whatever type or cacheability the region gives.
- R5: effShare equals regionShare whenever regionHit=1, inside a window or not.
- R6: Type encodings are 00 Strongly Ordered, 01 Device and 10 Normal. A hit region of type 00 or 01, or any hit region with regionXn=1, is non-executable. An instruction fetch (isFetch=1) there sets permFault.
- R7: The implicit execute-never of a type 00 or 01 region still applies when the address is inside a window.
- R8: Access size is encoded as 0 byte, 1 halfword and 2 word. Outside the windows, an access to a type 00 or 01 region whose address is not a multiple of its element size sets alignFault.
- R9: For isMulti=1 the element is a word whatever accSize is. Such an access faults only when accAddr[1:0] is not 00.
- R10: Inside a window, the ordered-type alignment rule does not apply. An unaligned non-multiple access there follows the Normal rule.
- R11: An unaligned Normal access faults only when strictAlignEn=1. A multiple-transfer access to Normal memory always needs word alignment.
- R12: When alignment and permission faults would both arise, alignFault=1 and permFault=0.
- R13: Type code 11 is handled as Strongly Ordered (effType reports 00). Size code 3 is handled as a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| accAddr | input | ADDR_W | Access byte address |
| accSize | input | 2 | Element size code |
| isFetch | input | 1 | Access is an instruction fetch |
| isMulti | input | 1 | Access is a multiple-word transfer |
| strictAlignEn | input | 1 | Enforce alignment on Normal memory |
| regionHit | input | 1 | A protection region matched |
| regionType | input | 2 | Memory type of the matched region |
| regionCache | input | 1 | Region cacheable bit |
| regionShare | input | 1 | Region shareable bit |
| regionXn | input | 1 | Region execute-never bit |
| tcmABase | input | ADDR_W | Window A base address |
| tcmAMask | input | ADDR_W | Window A offset mask |
| tcmAEn | input | 1 | Window A enable |
| tcmBBase | input | ADDR_W | Window B base address |
| tcmBMask | input | ADDR_W | Window B offset mask |
| tcmBEn | input | 1 | Window B enable |
| effType | output | 2 | Effective memory type |
| effCache | output | 1 | Effective cacheable |
| effShare | output | 1 | Effective shareable |
| alignFault | output | 1 | Alignment fault |
| permFault | output | 1 | Permission (execute) fault |
| tcmHit | output | 1 | Address lies in a window |

## Verification
An alignment fault and a permission fault can both arise in the same cycle. This happens on an unaligned instruction fetch to a Device or Strongly Ordered region outside the windows, or on an unaligned fetch to Normal memory with regionXn set and strict alignment on. The bench drives such fetches, both directed and mixed into a random sweep. It expects alignFault alone and permFault cleared. It also repeats the same fetch inside a window, where the alignment rule lapses and only permFault must appear.

// File: rtl/memattr_pkg.sv
package memattr_pkg;

  localparam int WORD_BYTES = 4;
  localparam int OFF_W      = $clog2(WORD_BYTES);

  typedef enum logic [1:0] {
    MT_STRONG = 2'b00,
    MT_DEVICE = 2'b01,
    MT_NORMAL = 2'b10,
    MT_RSVD   = 2'b11
  } memType_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } accSize_e;

  // strobes from the decision logic to the datapath
  typedef struct packed {
    logic useRegion;   // region attributes are valid
    logic forceNormal; // window hit overrides type and cacheability
    logic alignCheck;  // alignment must be enforced
    logic wordElem;    // element is a word regardless of size
    logic noExec;      // address is non-executable
    logic fetch;       // access is an instruction fetch
  } ctrlStrobe_t;

endpackage

// File: rtl/tcmWindowMatch.sv
module tcmWindowMatch #(
  parameter int ADDR_W  = 32,
  parameter int NUM_WIN = 2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] winBase [NUM_WIN],
  input  logic [ADDR_W-1:0] winMask [NUM_WIN],
  input  logic              winEn   [NUM_WIN],
  output logic              anyHit
);

  logic [NUM_WIN-1:0] perWin;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic [ADDR_W-1:0] diff;
    assign diff      = (addr ^ winBase[w]) & ~winMask[w];
    assign perWin[w] = winEn[w] && (diff == '0);
  end

  assign anyHit = |perWin;

endmodule

// File: rtl/attrControl.sv
module attrControl
  import memattr_pkg::*;
(
  input  logic        tcmHit,
  input  logic        regionHit,
  input  logic [1:0]  regionType,
  input  logic        regionXn,
  input  logic        isFetch,
  input  logic        isMulti,
  input  logic        strictAlignEn,
  output ctrlStrobe_t strobe
);

  logic orderedRegion;
  logic strictOrdered;

  // codes 00, 01 and reserved 11 are all ordered
  assign orderedRegion = regionHit && (regionType != MT_NORMAL);
  assign strictOrdered = orderedRegion && !tcmHit;

  always_comb begin
    strobe             = '0;
    strobe.useRegion   = regionHit;
    strobe.forceNormal = tcmHit;
    strobe.wordElem    = isMulti;
    strobe.alignCheck  = strictOrdered || strictAlignEn || isMulti;
    strobe.noExec      = orderedRegion || (regionHit && regionXn);
    strobe.fetch       = isFetch;
  end

endmodule

// File: rtl/attrDatapath.sv
module attrDatapath
  import memattr_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic [OFF_W-1:0] addrLow,
  input  logic [1:0]       accSize,
  input  logic [1:0]       regionType,
  input  logic             regionCache,
  input  logic             regionShare,
  input  logic             tcmHitIn,
  output logic [1:0]       effType,
  output logic             effCache,
  output logic             effShare,
  output logic             alignFault,
  output logic             permFault,
  output logic             tcmHit
);

  logic [1:0]       elemLog2;
  logic [OFF_W-1:0] offMask;
  logic             misaligned;
  logic             alignNext;
  logic             permNext;
  logic [1:0]       typeNext;
  logic             cacheNext;
  logic             shareNext;

  always_comb begin
    if (strobe.wordElem || accSize == SZ_RSVD) elemLog2 = 2'd2;
    else                                       elemLog2 = accSize;
    case (elemLog2)
      2'd0:    offMask = '0;
      2'd1:    offMask = OFF_W'(1);
      default: offMask = '1;
    endcase
  end

  assign misaligned = |(addrLow & offMask);
  assign alignNext  = strobe.alignCheck && misaligned;
  assign permNext   = strobe.fetch && strobe.noExec && !alignNext;

  always_comb begin
    if (!strobe.useRegion || strobe.forceNormal) typeNext = MT_NORMAL;
    else if (regionType == MT_RSVD)              typeNext = MT_STRONG;
    else                                         typeNext = regionType;
  end

  assign cacheNext = strobe.useRegion && !strobe.forceNormal &&
                     (regionType == MT_NORMAL) && regionCache;
  assign shareNext = strobe.useRegion && regionShare;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      effType    <= MT_NORMAL;
      effCache   <= 1'b0;
      effShare   <= 1'b0;
      alignFault <= 1'b0;
      permFault  <= 1'b0;
      tcmHit     <= 1'b0;
    end else begin
      effType    <= typeNext;
      effCache   <= cacheNext;
      effShare   <= shareNext;
      alignFault <= alignNext;
      permFault  <= permNext;
      tcmHit     <= tcmHitIn;
    end
  end

endmodule

// File: rtl/memAttrCheck.sv
module memAttrCheck
  import memattr_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic [1:0]        accSize,
  input  logic              isFetch,
  input  logic              isMulti,
  input  logic              strictAlignEn,
  input  logic              regionHit,
  input  logic [1:0]        regionType,
  input  logic              regionCache,
  input  logic              regionShare,
  input  logic              regionXn,
  input  logic [ADDR_W-1:0] tcmABase,
  input  logic [ADDR_W-1:0] tcmAMask,
  input  logic              tcmAEn,
  input  logic [ADDR_W-1:0] tcmBBase,
  input  logic [ADDR_W-1:0] tcmBMask,
  input  logic              tcmBEn,
  output logic [1:0]        effType,
  output logic              effCache,
  output logic              effShare,
  output logic              alignFault,
  output logic              permFault,
  output logic              tcmHit
);

  localparam int NUM_WIN = 2;

  logic [ADDR_W-1:0] winBase [NUM_WIN];
  logic [ADDR_W-1:0] winMask [NUM_WIN];
  logic              winEn   [NUM_WIN];
  logic              windowHit;
  ctrlStrobe_t       strobe;

  assign winBase[0] = tcmABase;
  assign winMask[0] = tcmAMask;
  assign winEn[0]   = tcmAEn;
  assign winBase[1] = tcmBBase;
  assign winMask[1] = tcmBMask;
  assign winEn[1]   = tcmBEn;

  tcmWindowMatch #(.ADDR_W(ADDR_W), .NUM_WIN(NUM_WIN)) u_match (
    .addr    (accAddr),
    .winBase (winBase),
    .winMask (winMask),
    .winEn   (winEn),
    .anyHit  (windowHit)
  );

  attrControl u_ctrl (
    .tcmHit        (windowHit),
    .regionHit     (regionHit),
    .regionType    (regionType),
    .regionXn      (regionXn),
    .isFetch       (isFetch),
    .isMulti       (isMulti),
    .strictAlignEn (strictAlignEn),
    .strobe        (strobe)
  );

  attrDatapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .addrLow     (accAddr[OFF_W-1:0]),
    .accSize     (accSize),
    .regionType  (regionType),
    .regionCache (regionCache),
    .regionShare (regionShare),
    .tcmHitIn    (windowHit),
    .effType     (effType),
    .effCache    (effCache),
    .effShare    (effShare),
    .alignFault  (alignFault),
    .permFault   (permFault),
    .tcmHit      (tcmHit)
  );

endmodule

// File: rtl/memAttrCheck_chk.sv
module memAttrCheck_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] addrLow,
  input logic [1:0] accSize,
  input logic       isFetch,
  input logic       isMulti,
  input logic       regionHit,
  input logic [1:0] regionType,
  input logic       regionShare,
  input logic       regionXn,
  input logic [1:0] effType,
  input logic       effCache,
  input logic       effShare,
  input logic       alignFault,
  input logic       permFault,
  input logic       tcmHit
);

  logic primed;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) primed <= 1'b0;
    else       primed <= 1'b1;
  end

  // R12
  fault_exclusive_chk: assert property (@(posedge clk) disable iff (!rstN)
    alignFault |-> !permFault);

  // R4
  tcm_normal_chk: assert property (@(posedge clk) disable iff (!rstN)
    tcmHit |-> (effType == 2'b10 && !effCache));

  // R5
  share_pass_chk: assert property (@(posedge clk) disable iff (!rstN || !primed)
    $past(regionHit) |-> (effShare == $past(regionShare)));

  // R3
  miss_default_chk: assert property (@(posedge clk) disable iff (!rstN || !primed)
    $past(!regionHit) |-> (effType == 2'b10 && !effCache && !effShare && !permFault));

  // R6
  xn_fetch_chk: assert property (@(posedge clk) disable iff (!rstN || !primed)
    $past(isFetch && regionHit && regionXn) |-> (permFault || alignFault));

  // R7
  ordered_xn_chk: assert property (@(posedge clk) disable iff (!rstN || !primed)
    $past(isFetch && regionHit && regionType != 2'b10) |-> (permFault || alignFault));

  // R11
  byte_never_chk: assert property (@(posedge clk) disable iff (!rstN || !primed)
    $past(!isMulti && accSize == 2'b00) |-> !alignFault);

  // R9
  multi_word_chk: assert property (@(posedge clk) disable iff (!rstN || !primed)
    $past(isMulti && addrLow == 2'b00) |-> !alignFault);

endmodule

bind memAttrCheck memAttrCheck_chk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .addrLow     (accAddr[1:0]),
  .accSize     (accSize),
  .isFetch     (isFetch),
  .isMulti     (isMulti),
  .regionHit   (regionHit),
  .regionType  (regionType),
  .regionShare (regionShare),
  .regionXn    (regionXn),
  .effType     (effType),
  .effCache    (effCache),
  .effShare    (effShare),
  .alignFault  (alignFault),
  .permFault   (permFault),
  .tcmHit      (tcmHit)
);

// File: tb/memAttrCheck_tb.sv
module memAttrCheck_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] accAddr = '0;
  logic [1:0]  accSize = '0;
  logic        isFetch = 0, isMulti = 0, strictAlignEn = 0;
  logic        regionHit = 0, regionCache = 0, regionShare = 0, regionXn = 0;
  logic [1:0]  regionType = 2'b10;
  logic [31:0] tcmABase = 32'h0000_0000, tcmAMask = 32'h0000_FFFF;
  logic [31:0] tcmBBase = 32'h0010_0000, tcmBMask = 32'h0000_3FFF;
  logic        tcmAEn = 1'b1, tcmBEn = 1'b1;
  logic [1:0]  effType;
  logic        effCache, effShare, alignFault, permFault, tcmHit;

  int    checks = 0;
  int    errors = 0;
  string curTag = "R2";
  string expTag;
  logic [6:0] expVec;
  logic  expValid = 1'b0;

  always #10 clk = ~clk;

  memAttrCheck #(.ADDR_W(32)) u_dut (
    .clk(clk), .rstN(rstN), .accAddr(accAddr), .accSize(accSize),
    .isFetch(isFetch), .isMulti(isMulti), .strictAlignEn(strictAlignEn),
    .regionHit(regionHit), .regionType(regionType), .regionCache(regionCache),
    .regionShare(regionShare), .regionXn(regionXn),
    .tcmABase(tcmABase), .tcmAMask(tcmAMask), .tcmAEn(tcmAEn),
    .tcmBBase(tcmBBase), .tcmBMask(tcmBMask), .tcmBEn(tcmBEn),
    .effType(effType), .effCache(effCache), .effShare(effShare),
    .alignFault(alignFault), .permFault(permFault), .tcmHit(tcmHit)
  );

  // reference: {type[1:0], cache, share, align, perm, tcm}
  function automatic logic [6:0] refModel();
    bit inWin, ordered, execBlocked, mustAlign, off, af, pf, ca, sh;
    int bytes;
    logic [1:0] ty;
    inWin = (tcmAEn && (((accAddr ^ tcmABase) & ~tcmAMask) == 0)) ||
            (tcmBEn && (((accAddr ^ tcmBBase) & ~tcmBMask) == 0));
    ordered = regionHit && (regionType == 2'b00 || regionType == 2'b01 || regionType == 2'b11);
    execBlocked = ordered || (regionHit && regionXn);
    if (isMulti) bytes = 4;
    else if (accSize == 0) bytes = 1;
    else if (accSize == 1) bytes = 2;
    else bytes = 4;
    off = (accAddr % bytes) != 0;
    mustAlign = isMulti || strictAlignEn || (ordered && !inWin);
    af = mustAlign && off;
    pf = isFetch && execBlocked && !af;
    if (!regionHit || inWin) ty = 2'b10;
    else if (regionType == 2'b11) ty = 2'b00;
    else ty = regionType;
    ca = regionHit && !inWin && regionType == 2'b10 && regionCache;
    sh = regionHit && regionShare;
    return {ty, ca, sh, af, pf, inWin};
  endfunction

  always @(posedge clk) begin
    if (!rstN) expValid <= 1'b0;
    else begin
      expVec   <= refModel();
      expTag   <= curTag;
      expValid <= 1'b1;
    end
  end

  always @(negedge clk) begin
    if (expValid && rstN) begin
      checks++;
      if ({effType, effCache, effShare, alignFault, permFault, tcmHit} !== expVec) begin
        errors++;
        $display("FAIL %s: got type=%b c=%b s=%b af=%b pf=%b tcm=%b exp type=%b c=%b s=%b af=%b pf=%b tcm=%b",
                 expTag, effType, effCache, effShare, alignFault, permFault, tcmHit,
                 expVec[6:5], expVec[4], expVec[3], expVec[2], expVec[1], expVec[0]);
      end
    end
  end

  task automatic drive(string tag, logic [31:0] a, logic [1:0] sz, bit f, bit m, bit st,
                       bit hit, logic [1:0] ty, bit c, bit s, bit x);
    @(negedge clk);
    curTag = tag; accAddr = a; accSize = sz; isFetch = f; isMulti = m;
    strictAlignEn = st; regionHit = hit; regionType = ty;
    regionCache = c; regionShare = s; regionXn = x;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    // R1: reset state
    drive("R1", 32'h2000_0003, 2'd2, 1, 1, 1, 1, 2'b01, 1, 1, 1);
    repeat (3) @(negedge clk);
    checks++;
    if ({effType, effCache, effShare, alignFault, permFault, tcmHit} !== 7'b10_0_0_0_0_0) begin
      errors++;
      $display("FAIL R1: got %b exp 1000000",
               {effType, effCache, effShare, alignFault, permFault, tcmHit});
    end
    rstN = 1'b1;

    // R3: no region hit
    drive("R3", 32'h2000_0001, 2'd2, 1, 0, 0, 0, 2'b00, 1, 1, 1);
    drive("R3", 32'h2000_0000, 2'd2, 0, 0, 0, 1, 2'b10, 1, 0, 0);
    drive("R3", 32'h2000_0000, 2'd2, 0, 0, 0, 1, 2'b01, 1, 0, 0);
    // R4: window hits override type and cacheability
    drive("R4", 32'h0000_1234, 2'd0, 0, 0, 0, 1, 2'b01, 1, 0, 0);
    drive("R4", 32'h0010_3FFC, 2'd2, 0, 0, 0, 1, 2'b10, 1, 0, 0);
    drive("R4", 32'h0010_4000, 2'd2, 0, 0, 0, 1, 2'b10, 1, 0, 0);
    // R5: shareable passes through, window or not
    drive("R5", 32'h0000_0010, 2'd2, 0, 0, 0, 1, 2'b00, 0, 1, 0);
    drive("R5", 32'h3000_0010, 2'd2, 0, 0, 0, 1, 2'b10, 0, 1, 0);
    // R6: execute-never
    drive("R6", 32'h3000_0000, 2'd2, 1, 0, 0, 1, 2'b01, 0, 0, 0);
    drive("R6", 32'h3000_0000, 2'd2, 1, 0, 0, 1, 2'b10, 1, 0, 1);
    drive("R6", 32'h3000_0000, 2'd2, 1, 0, 0, 1, 2'b10, 1, 0, 0);
    // R7: implicit XN inside a window
    drive("R7", 32'h0000_0100, 2'd2, 1, 0, 0, 1, 2'b00, 0, 0, 0);
    drive("R7", 32'h0010_0102, 2'd1, 1, 0, 0, 1, 2'b01, 0, 0, 0);
    // R8: natural alignment on ordered memory
    drive("R8", 32'h3000_0001, 2'd1, 0, 0, 0, 1, 2'b01, 0, 0, 0);
    drive("R8", 32'h3000_0002, 2'd2, 0, 0, 0, 1, 2'b00, 0, 0, 0);
    drive("R8", 32'h3000_0002, 2'd1, 0, 0, 0, 1, 2'b00, 0, 0, 0);
    drive("R8", 32'h3000_0003, 2'd0, 0, 0, 0, 1, 2'b01, 0, 0, 0);
    // R9: multiple transfers use word elements
    drive("R9", 32'h3000_0004, 2'd0, 0, 1, 0, 1, 2'b01, 0, 0, 0);
    drive("R9", 32'h3000_0002, 2'd1, 0, 1, 0, 1, 2'b00, 0, 0, 0);
    // R10: window cancels ordered alignment
    drive("R10", 32'h0000_0001, 2'd2, 0, 0, 0, 1, 2'b01, 0, 0, 0);
    drive("R10", 32'h0010_0003, 2'd1, 0, 0, 1, 1, 2'b00, 0, 0, 0);
    // R11: Normal alignment
    drive("R11", 32'h3000_0001, 2'd2, 0, 0, 0, 1, 2'b10, 1, 0, 0);
    drive("R11", 32'h3000_0001, 2'd2, 0, 0, 1, 1, 2'b10, 1, 0, 0);
    drive("R11", 32'h3000_0002, 2'd2, 0, 1, 0, 1, 2'b10, 1, 0, 0);
    // R12: alignment fault wins over permission fault
    drive("R12", 32'h3000_0002, 2'd2, 1, 0, 0, 1, 2'b01, 0, 0, 0);
    drive("R12", 32'h3000_0001, 2'd1, 1, 0, 1, 1, 2'b10, 0, 0, 1);
    drive("R12", 32'h0000_0002, 2'd2, 1, 0, 0, 1, 2'b01, 0, 0, 0);
    // R13: reserved codes
    drive("R13", 32'h3000_0002, 2'd2, 0, 0, 0, 1, 2'b11, 1, 0, 0);
    drive("R13", 32'h3000_0002, 2'd3, 0, 0, 0, 1, 2'b00, 0, 0, 0);
    // R4: disabled window no longer matches
    @(negedge clk); tcmAEn = 1'b0;
    drive("R4", 32'h0000_0001, 2'd2, 0, 0, 0, 1, 2'b01, 0, 0, 0);
    @(negedge clk); tcmAEn = 1'b1;
    // R2: back-to-back random sweep, one result per cycle
    for (int i = 0; i < 600; i++) begin
      logic [31:0] base;
      case ($urandom_range(0, 2))
        0: base = 32'h0000_0000;
        1: base = 32'h0010_0000;
        default: base = 32'h4000_0000;
      endcase
      drive("R2", base | ($urandom() & 32'h0000_7FFF), 2'($urandom()),
            1'($urandom()), 1'($urandom()), 1'($urandom()), 1'($urandom()),
            2'($urandom()), 1'($urandom()), 1'($urandom()), 1'($urandom()));
    end
    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule